// File: doc/BRIEF.md
# Byte-Wide Host Register Bridge

This block connects an 8-bit synchronous host port to an internal register bus that many modules share. The host port carries one byte lane and three control lines: a request line, a write/not-read line and an address-phase flag. Because a register is exactly as wide as the host byte lane, each access takes two phases. First the host raises request together with the address flag, and the bridge latches the byte as an address. Then the host raises request without the flag, and the byte is either written into the selected register or replaced by that register's read value.

The latched byte is split into a module select (upper three bits) and a register select (lower five bits). The bridge forwards request, direction, write data and both selects onto the internal bus. For every module/register slot it also produces a read level and a write level, each high for as long as that slot is being accessed. From these levels it derives single-cycle pulses. The write pulse marks the completion of a write. The read pulse marks the start of a read, so the register owner has time to present a value before the host captures it. The bridge owns module 0: an identification register and a scratch register. It also generates the half-rate interface clock, so the whole design runs from one system clock.

Top module: `host_reg_bridge`

## Requirements
- R1: `ifclk_o` is low during reset and toggles on every rising edge of `clk` afterwards. The host control lines and data are sampled only on edges where `ifclk_o` is high before the edge, so each sampled value holds for two clocks.
- R2: A sampled request with the address flag set latches the data byte. `bus_msel_o` = byte[7:5] and `bus_rsel_o` = byte[4:0]. No level strobe is active during an address phase.
- R3: `bus_req_o` is high only while a sampled request without the address flag is present. `bus_wr_o` follows the sampled write line, `bus_wdata_o` follows the sampled data byte, and both selects stay constant while `bus_req_o` stays high.
- R4: A slot is mapped when module < NUM_MOD and register < REGS_PER_MOD, and its slot index is module*REGS_PER_MOD+register. During a data-phase write to a mapped slot, `wr_lvl_o` has exactly that bit set, and likewise `rd_lvl_o` for a read. Unmapped addresses set no bit.
- R5: Each write produces exactly one `wr_pls_o` pulse on its slot, one clock long, in the first cycle after the slot's write level has fallen.
- R6: Each read produces exactly one `rd_pls_o` pulse on its slot, one clock long, in the first cycle the slot's read level is high.
- R7: Module 0 register 0 reads ID_VALUE (default 8'hA5), and writes to it have no effect.
- R8: Module 0 register 1 is a scratch register that resets to 8'h00 and reads back the last byte written. Address-phase bytes never change it.
- R9: A read of module m≥1, register r returns byte k = (m-1)*REGS_PER_MOD+r of `ext_rdata_i` (bits k*8+7..k*8). Reads of unmapped addresses, and of module 0 registers 2 and above, return 8'h00.
- R10: `hdata_oe_o` is high only while a sampled read data phase is present (request, no address flag, write line low). It is low in reset, during address phases, during writes and while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ifclk_o | output | 1 | Host interface clock, half the system rate |
| hctl_req_i | input | 1 | Host request line |
| hctl_wr_i | input | 1 | Host write (1) / read (0) line |
| hctl_adr_i | input | 1 | Host address-phase flag |
| hdata_i | input | 8 | Host byte lane, inbound |
| hdata_o | output | 8 | Host byte lane, outbound read data |
| hdata_oe_o | output | 1 | Output enable for the host byte lane |
| bus_req_o | output | 1 | Internal bus request |
| bus_wr_o | output | 1 | Internal bus direction, 1 = write |
| bus_msel_o | output | 3 | Latched module select |
| bus_rsel_o | output | 5 | Latched register select |
| bus_wdata_o | output | 8 | Internal bus write data |
| ext_rdata_i | input | (NUM_MOD-1)*REGS_PER_MOD*8 | Read values of the registers in modules 1 and up, one byte per slot |
| wr_lvl_o | output | NUM_MOD*REGS_PER_MOD | Per-slot write level |
| rd_lvl_o | output | NUM_MOD*REGS_PER_MOD | Per-slot read level |
| wr_pls_o | output | NUM_MOD*REGS_PER_MOD | Per-slot write-complete pulse |
| rd_pls_o | output | NUM_MOD*REGS_PER_MOD | Per-slot read-start pulse |

## Verification
The bench writes and then reads every module select, together with register selects that lie inside, just past and far past the mapped range. This catches a decoder that wraps an out-of-range register onto a real slot, which would show up as stray pulses or non-zero read data on unmapped addresses. Pulse timing is watched on every cycle against the level outputs. A pulse tied to the wrong edge, or one that lasts two clocks, breaks the "after the write level falls" and "when the read level rises" rules. Address-phase bytes that equal the scratch register's own address are sent between scratch accesses, so a bridge that treats the address phase as a write would corrupt the scratch value. The ID register is written before it is read, to show that writes do not reach it.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
   localparam int BYTE_W = 8;
   localparam int MSEL_W = 3;
   localparam int RSEL_W = 5;

   typedef struct packed {
      logic              req;
      logic              wr;
      logic              adr;
      logic [BYTE_W-1:0] data;
   } host_smp_t;
endpackage

// File: rtl/hbr_host_sampler.sv
module hbr_host_sampler
   import hbr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_req_i,
   input  logic              ctl_wr_i,
   input  logic              ctl_adr_i,
   input  logic [BYTE_W-1:0] data_i,
   output logic              ifclk_o,
   output host_smp_t         smp_o
);
   logic      ifclk_q;
   host_smp_t smp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) ifclk_q <= 1'b0;
      else        ifclk_q <= ~ifclk_q;
   end

   // capture host lines once per interface period
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         smp_q <= '0;
      end else if (ifclk_q) begin
         smp_q.req  <= ctl_req_i;
         smp_q.wr   <= ctl_wr_i;
         smp_q.adr  <= ctl_adr_i;
         smp_q.data <= data_i;
      end
   end

   assign ifclk_o = ifclk_q;
   assign smp_o   = smp_q;

   // R1
   ifclk_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ifclk_q |=> !ifclk_q);
   // R1
   ifclk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ifclk_q |=> ifclk_q);
   // R1
   smp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ifclk_q |=> $stable(smp_q));
endmodule

// File: rtl/hbr_addr_decode.sv
module hbr_addr_decode
   import hbr_pkg::*;
#(
   parameter  int NUM_MOD      = 4,
   parameter  int REGS_PER_MOD = 4,
   localparam int NSLOT        = NUM_MOD * REGS_PER_MOD
)(
   input  logic              clk,
   input  logic              rst_n,
   input  host_smp_t         smp_i,
   output logic [MSEL_W-1:0] msel_o,
   output logic [RSEL_W-1:0] rsel_o,
   output logic [NSLOT-1:0]  sel_o
);
   localparam logic [MSEL_W:0] MOD_LIM = (MSEL_W+1)'(NUM_MOD);
   localparam logic [RSEL_W:0] REG_LIM = (RSEL_W+1)'(REGS_PER_MOD);

   logic [BYTE_W-1:0] addr_q;
   logic              hit;

   // address phase: the byte is an address, never register data
   always_ff @(posedge clk) begin
      if (!rst_n)                      addr_q <= '0;
      else if (smp_i.req && smp_i.adr) addr_q <= smp_i.data;
   end

   assign msel_o = addr_q[BYTE_W-1 -: MSEL_W];
   assign rsel_o = addr_q[RSEL_W-1:0];
   assign hit    = ({1'b0, msel_o} < MOD_LIM) && ({1'b0, rsel_o} < REG_LIM);

   for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
      for (genvar r = 0; r < REGS_PER_MOD; r++) begin : g_reg
         assign sel_o[m*REGS_PER_MOD + r] = hit
                                          && (msel_o == MSEL_W'(m))
                                          && (rsel_o == RSEL_W'(r));
      end
   end

   // R4
   sel_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_o));
endmodule

// File: rtl/hbr_strobe_gen.sv
module hbr_strobe_gen #(
   parameter int NSLOT = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSLOT-1:0] sel_i,
   input  logic             wr_phase_i,
   input  logic             rd_phase_i,
   output logic [NSLOT-1:0] wr_lvl_o,
   output logic [NSLOT-1:0] rd_lvl_o,
   output logic [NSLOT-1:0] wr_pls_o,
   output logic [NSLOT-1:0] rd_pls_o
);
   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      logic wr_lvl, rd_lvl, wr_dly, rd_dly;

      assign wr_lvl = sel_i[i] & wr_phase_i;
      assign rd_lvl = sel_i[i] & rd_phase_i;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            wr_dly <= 1'b0;
            rd_dly <= 1'b0;
         end else begin
            wr_dly <= wr_lvl;
            rd_dly <= rd_lvl;
         end
      end

      // write completes on the falling level, read starts on the rising one
      assign wr_lvl_o[i] = wr_lvl;
      assign rd_lvl_o[i] = rd_lvl;
      assign wr_pls_o[i] = wr_dly & ~wr_lvl;
      assign rd_pls_o[i] = rd_lvl & ~rd_dly;

      // R5
      wr_pls_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
         wr_pls_o[i] |=> !wr_pls_o[i]);
      // R6
      rd_pls_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rd_pls_o[i] |=> !rd_pls_o[i]);
   end
endmodule

// File: rtl/hbr_local_regs.sv
module hbr_local_regs
   import hbr_pkg::*;
#(
   parameter logic [BYTE_W-1:0] ID_VALUE = 8'hA5
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scr_we_i,
   input  logic [BYTE_W-1:0] wdata_i,
   output logic [BYTE_W-1:0] id_o,
   output logic [BYTE_W-1:0] scratch_o
);
   logic [BYTE_W-1:0] scratch_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        scratch_q <= '0;
      else if (scr_we_i) scratch_q <= wdata_i;
   end

   assign id_o      = ID_VALUE;
   assign scratch_o = scratch_q;

   // R8
   scratch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !scr_we_i |=> $stable(scratch_q));
endmodule

// File: rtl/host_reg_bridge.sv
module host_reg_bridge
   import hbr_pkg::*;
#(
   parameter  int                NUM_MOD      = 4,
   parameter  int                REGS_PER_MOD = 4,
   parameter  logic [BYTE_W-1:0] ID_VALUE     = 8'hA5,
   localparam int                NSLOT        = NUM_MOD * REGS_PER_MOD,
   localparam int                EXT_SLOTS    = (NUM_MOD - 1) * REGS_PER_MOD,
   localparam int                EXT_W        = EXT_SLOTS * BYTE_W
)(
   input  logic              clk,
   input  logic              rst_n,
   output logic              ifclk_o,
   input  logic              hctl_req_i,
   input  logic              hctl_wr_i,
   input  logic              hctl_adr_i,
   input  logic [BYTE_W-1:0] hdata_i,
   output logic [BYTE_W-1:0] hdata_o,
   output logic              hdata_oe_o,
   output logic              bus_req_o,
   output logic              bus_wr_o,
   output logic [MSEL_W-1:0] bus_msel_o,
   output logic [RSEL_W-1:0] bus_rsel_o,
   output logic [BYTE_W-1:0] bus_wdata_o,
   input  logic [EXT_W-1:0]  ext_rdata_i,
   output logic [NSLOT-1:0]  wr_lvl_o,
   output logic [NSLOT-1:0]  rd_lvl_o,
   output logic [NSLOT-1:0]  wr_pls_o,
   output logic [NSLOT-1:0]  rd_pls_o
);
   // elaboration checks on the configuration
   if (NUM_MOD < 2 || NUM_MOD > (1 << MSEL_W)) begin : g_bad_mod
      $error("NUM_MOD must lie in 2..8");
   end
   if (REGS_PER_MOD < 2 || REGS_PER_MOD > (1 << RSEL_W)) begin : g_bad_regs
      $error("REGS_PER_MOD must lie in 2..32");
   end

   localparam int SCR_SLOT = 1;

   host_smp_t         smp;
   logic [NSLOT-1:0]  sel;
   logic              wr_phase, rd_phase;
   logic [BYTE_W-1:0] id_val, scr_val;
   logic [BYTE_W-1:0] slot_rd [NSLOT];
   logic [BYTE_W-1:0] rd_byte;

   hbr_host_sampler u_smp (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_req_i(hctl_req_i),
      .ctl_wr_i (hctl_wr_i),
      .ctl_adr_i(hctl_adr_i),
      .data_i   (hdata_i),
      .ifclk_o  (ifclk_o),
      .smp_o    (smp)
   );

   hbr_addr_decode #(
      .NUM_MOD     (NUM_MOD),
      .REGS_PER_MOD(REGS_PER_MOD)
   ) u_dec (
      .clk   (clk),
      .rst_n (rst_n),
      .smp_i (smp),
      .msel_o(bus_msel_o),
      .rsel_o(bus_rsel_o),
      .sel_o (sel)
   );

   assign wr_phase = smp.req & ~smp.adr &  smp.wr;
   assign rd_phase = smp.req & ~smp.adr & ~smp.wr;

   hbr_strobe_gen #(.NSLOT(NSLOT)) u_stb (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_i     (sel),
      .wr_phase_i(wr_phase),
      .rd_phase_i(rd_phase),
      .wr_lvl_o  (wr_lvl_o),
      .rd_lvl_o  (rd_lvl_o),
      .wr_pls_o  (wr_pls_o),
      .rd_pls_o  (rd_pls_o)
   );

   hbr_local_regs #(.ID_VALUE(ID_VALUE)) u_loc (
      .clk      (clk),
      .rst_n    (rst_n),
      .scr_we_i (wr_lvl_o[SCR_SLOT]),
      .wdata_i  (smp.data),
      .id_o     (id_val),
      .scratch_o(scr_val)
   );

   // per-slot read sources: module 0 is local, the rest come from outside
   for (genvar i = 0; i < NSLOT; i++) begin : g_src
      if (i == 0) begin : g_id
         assign slot_rd[i] = id_val;
      end else if (i == SCR_SLOT) begin : g_scr
         assign slot_rd[i] = scr_val;
      end else if (i < REGS_PER_MOD) begin : g_none
         assign slot_rd[i] = '0;
      end else begin : g_ext
         assign slot_rd[i] = ext_rdata_i[(i-REGS_PER_MOD)*BYTE_W +: BYTE_W];
      end
   end

   // AND-OR mux on the one-hot select; no select yields zero
   always_comb begin
      rd_byte = '0;
      for (int i = 0; i < NSLOT; i++) begin
         rd_byte = rd_byte | (slot_rd[i] & {BYTE_W{sel[i]}});
      end
   end

   assign bus_req_o   = smp.req & ~smp.adr;
   assign bus_wr_o    = smp.wr;
   assign bus_wdata_o = smp.data;
   assign hdata_o     = rd_byte;
   assign hdata_oe_o  = rd_phase;

   // R10
   oe_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hdata_oe_o |-> (bus_req_o && !bus_wr_o));
   // R3
   sel_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && $past(bus_req_o)) |-> ($stable(bus_msel_o) && $stable(bus_rsel_o)));
   // R2
   no_lvl_in_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_req_o |-> (wr_lvl_o == '0 && rd_lvl_o == '0));
   // R4
   lvl_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_lvl_o | rd_lvl_o));
endmodule

// File: tb/tb_host_reg_bridge.sv
`timescale 1ns/1ps
module tb_host_reg_bridge;
   localparam int NM    = 4;
   localparam int RG    = 4;
   localparam int NSLOT = NM * RG;
   localparam int EXTW  = (NM - 1) * RG * 8;
   localparam logic [7:0] IDV = 8'hA5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ifclk;
   logic             req = 1'b0, wr = 1'b0, adr = 1'b0;
   logic [7:0]       hdi = '0;
   logic [7:0]       hdo;
   logic             hoe;
   logic             breq, bwr;
   logic [2:0]       bmsel;
   logic [4:0]       brsel;
   logic [7:0]       bwdata;
   logic [EXTW-1:0]  ext;
   logic [NSLOT-1:0] wl, rl, wp, rp;

   int total = 0;
   int bad   = 0;
   int wcnt [NSLOT];
   int rcnt [NSLOT];
   logic [NSLOT-1:0] wl_prev = '0, rl_prev = '0;
   logic [7:0] scr_model = 8'h00;

   always #2.5 clk = ~clk;

   host_reg_bridge dut (
      .clk(clk), .rst_n(rst_n), .ifclk_o(ifclk),
      .hctl_req_i(req), .hctl_wr_i(wr), .hctl_adr_i(adr),
      .hdata_i(hdi), .hdata_o(hdo), .hdata_oe_o(hoe),
      .bus_req_o(breq), .bus_wr_o(bwr), .bus_msel_o(bmsel), .bus_rsel_o(brsel),
      .bus_wdata_o(bwdata), .ext_rdata_i(ext),
      .wr_lvl_o(wl), .rd_lvl_o(rl), .wr_pls_o(wp), .rd_pls_o(rp)
   );

   initial begin
      for (int k = 0; k < NSLOT; k++) begin
         wcnt[k] = 0;
         rcnt[k] = 0;
      end
      for (int k = 0; k < (NM-1)*RG; k++) ext[k*8 +: 8] = 8'(8'h40 + k*7);
   end

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // pulse monitor: counts pulses and checks their placement against the levels
   always @(negedge clk) begin
      if (rst_n) begin
         for (int k = 0; k < NSLOT; k++) begin
            if (wp[k]) begin
               wcnt[k]++;
               total++;
               if (wl[k] || !wl_prev[k]) begin
                  bad++;
                  $display("FAIL R5 slot %0d: actual lvl=%0b prev=%0b expected lvl=0 prev=1",
                           k, wl[k], wl_prev[k]);
               end
            end
            if (rp[k]) begin
               rcnt[k]++;
               total++;
               if (!rl[k] || rl_prev[k]) begin
                  bad++;
                  $display("FAIL R6 slot %0d: actual lvl=%0b prev=%0b expected lvl=1 prev=0",
                           k, rl[k], rl_prev[k]);
               end
            end
         end
      end
      wl_prev <= wl;
      rl_prev <= rl;
   end

   task automatic drive(input logic q, input logic w, input logic a,
                        input logic [7:0] d, input int n);
      req = q; wr = w; adr = a; hdi = d;
      repeat (n) @(negedge clk);
   endtask

   function automatic logic mapped(input int m, input int r);
      return (m < NM) && (r < RG);
   endfunction

   function automatic logic [7:0] exp_rd(input int m, input int r);
      if (!mapped(m, r)) return 8'h00;
      if (m == 0) begin
         if (r == 0) return IDV;
         if (r == 1) return scr_model;
         return 8'h00;
      end
      return 8'(8'h40 + ((m-1)*RG + r)*7);
   endfunction

   task automatic addr_phase(input int m, input int r);
      drive(1'b1, 1'b1, 1'b1, {3'(m), 5'(r)}, 4);
      chk("R3 bus_req low in address phase", int'(breq), 0);
      chk("R10 oe low in address phase", int'(hoe), 0);
      chk("R2 no level in address phase", int'(wl | rl), 0);
      drive(1'b0, 1'b0, 1'b0, 8'h00, 2);
   endtask

   task automatic write_tx(input int m, input int r, input logic [7:0] d);
      int w0 [NSLOT];
      int r0 [NSLOT];
      int mism;
      logic [NSLOT-1:0] exp_l;
      addr_phase(m, r);
      for (int k = 0; k < NSLOT; k++) begin w0[k] = wcnt[k]; r0[k] = rcnt[k]; end
      exp_l = mapped(m, r) ? (NSLOT'(1) << (m*RG + r)) : '0;
      drive(1'b1, 1'b1, 1'b0, d, 4);
      chk("R2 module select", int'(bmsel), m);
      chk("R2 register select", int'(brsel), r);
      chk("R3 bus_req in data phase", int'(breq), 1);
      chk("R3 bus_wr in write", int'(bwr), 1);
      chk("R3 write data", int'(bwdata), int'(d));
      chk("R10 oe low in write", int'(hoe), 0);
      chk("R4 write level", int'(wl), int'(exp_l));
      drive(1'b0, 1'b0, 1'b0, 8'h00, 4);
      mism = 0;
      for (int k = 0; k < NSLOT; k++) begin
         if (wcnt[k] - w0[k] != int'(exp_l[k])) mism++;
         if (rcnt[k] != r0[k]) mism++;
      end
      chk("R5 write pulse count mismatches", mism, 0);
      if (m == 0 && r == 1) scr_model = d;
   endtask

   task automatic read_tx(input int m, input int r);
      int w0 [NSLOT];
      int r0 [NSLOT];
      int mism;
      logic [NSLOT-1:0] exp_l;
      addr_phase(m, r);
      for (int k = 0; k < NSLOT; k++) begin w0[k] = wcnt[k]; r0[k] = rcnt[k]; end
      exp_l = mapped(m, r) ? (NSLOT'(1) << (m*RG + r)) : '0;
      drive(1'b1, 1'b0, 1'b0, 8'hFF, 4);
      chk("R10 oe high in read", int'(hoe), 1);
      chk("R3 bus_wr low in read", int'(bwr), 0);
      chk("R4 read level", int'(rl), int'(exp_l));
      if (m == 0 && r == 0)      chk("R7 id value", int'(hdo), int'(exp_rd(m, r)));
      else if (m == 0 && r == 1) chk("R8 scratch value", int'(hdo), int'(exp_rd(m, r)));
      else                       chk("R9 read data", int'(hdo), int'(exp_rd(m, r)));
      drive(1'b0, 1'b0, 1'b0, 8'h00, 4);
      chk("R10 oe low after read", int'(hoe), 0);
      mism = 0;
      for (int k = 0; k < NSLOT; k++) begin
         if (rcnt[k] - r0[k] != int'(exp_l[k])) mism++;
         if (wcnt[k] != w0[k]) mism++;
      end
      chk("R6 read pulse count mismatches", mism, 0);
   endtask

   initial begin
      logic f0, f1;
      repeat (3) @(negedge clk);
      chk("R1 ifclk low in reset", int'(ifclk), 0);
      chk("R10 oe low in reset", int'(hoe), 0);
      chk("R5 no pulses in reset", int'(wp | rp), 0);
      rst_n = 1'b1;
      @(negedge clk);
      f0 = ifclk;
      @(negedge clk);
      f1 = ifclk;
      chk("R1 ifclk toggles", int'(f0 ^ f1), 1);
      drive(1'b0, 1'b0, 1'b0, 8'h00, 4);
      chk("R10 oe low when idle", int'(hoe), 0);

      // reset values of the local registers, ID ignores writes
      read_tx(0, 1);
      read_tx(0, 0);
      write_tx(0, 0, 8'h3E);
      read_tx(0, 0);

      // address phases that carry the scratch address leave it untouched
      write_tx(0, 1, 8'h3C);
      addr_phase(0, 1);
      addr_phase(1, 1);
      read_tx(0, 1);

      // sweep modules and in-range, just-past and far-past register selects
      for (int m = 0; m < 8; m++) begin
         for (int j = 0; j < 6; j++) begin
            int r;
            r = (j == 5) ? 31 : j;
            write_tx(m, r, 8'(m*37 + r*11 + 3));
            read_tx(m, r);
         end
      end
      read_tx(0, 1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule